// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when the contents of an SRAM array are copied into a shadow nonvolatile array, which is a store, and when they are copied back, which is a recall. A store can be requested in three ways: by an active-low hardware store pin, by a software store strobe, or by a power-fail comparator. A recall is requested once, automatically, when reset is released. The block does not move any data itself. It hands each transfer to a separate store/recall engine through a request level, and it waits for a one-cycle done pulse in return.

The block keeps a dirty flag that records whether the host has written the array since the last transfer. Hardware-pin stores and power-fail stores are skipped while the flag is clear. Software stores always run. Every accepted store first passes through a hold window of `HOLD_CYCLES` clock cycles. During this window, host accesses already under way may still finish. The open-drain style busy output is pulled low from the start of the hold window until the engine reports that the store is done. Host reads and writes are decoded from the chip, output and write enable strobes, and they are blocked while a transfer runs. After a store, host access also stays blocked until the hardware store pin is high again.

Top module: `nvs_seq_top`

## Requirements
- R1: From reset, `eng_recall_req` is high and stays high until `eng_done` is seen. Host enables stay low during this time. The engine's done pulse also clears the dirty flag.
- R2: `host_rd_en` is 1 exactly when `host_ce_n`=0, `host_oe_n`=0, `host_we_n`=1 and `hw_store_n`=1, and host access is allowed.
- R3: `host_wr_en` is 1 exactly when `host_ce_n`=0, `host_we_n`=0 and `hw_store_n`=1, and host access is allowed. `host_oe_n` is a don't-care for writes.
- R4: While the dirty flag is clear, holding `hw_store_n` low is ignored: `busy_n` stays 1 and `eng_store_req` stays 0.
- R5: With `AUTO_STORE_EN`=1 (the default), a high `pwr_fail` starts a store when the flag is dirty, or when a host write is decoded in that same cycle. Otherwise `pwr_fail` is ignored.
- R6: A `sw_store` pulse in the idle state starts a store even when the dirty flag is clear.
- R7: Suppose a request is accepted at clock edge E. Then `eng_store_req` rises after edge E+`HOLD_CYCLES`. Until then, host reads are still decoded.
- R8: `busy_n` is 0 from the edge after acceptance until the edge that samples `eng_done`. It is 1 afterwards.
- R9: Host enables are 0 whenever `eng_store_req` or `eng_recall_req` is 1.
- R10: After a store completes, host access stays blocked while `hw_store_n` is low. Access is allowed again from the edge after the pin is sampled high.
- R11: A completed store clears the dirty flag. Without a new write, a later hardware store request is ignored.
- R12: Store requests that arrive while a transfer is active are dropped, not queued. A `sw_store` pulse during a store does not produce a second store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| hw_store_n | input | 1 | Hardware store request pin, active low |
| sw_store | input | 1 | Software store strobe |
| pwr_fail | input | 1 | Supply below switch threshold |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| host_rd_en | output | 1 | Gated array read enable |
| host_wr_en | output | 1 | Gated array write enable |
| busy_n | output | 1 | Busy indication, low during a store |
| eng_store_req | output | 1 | Store transfer request to the engine |
| eng_recall_req | output | 1 | Recall transfer request to the engine |

## Verification
Two events can fall in the same cycle: a host write being decoded and a power-fail request being judged against the dirty flag. The bench starts from a clean flag after a completed store. It raises `pwr_fail` in the same cycle as a write strobe and expects `busy_n` to fall on the next edge. Before that, it shows that `pwr_fail` alone, with the flag clean, leaves `busy_n` high. A second overlap puts a `sw_store` pulse inside an active store. The bench counts the rising edges of `eng_store_req` to confirm that only one store runs.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [2:0] {
      NVS_RECALL = 3'd0,
      NVS_IDLE   = 3'd1,
      NVS_HOLD   = 3'd2,
      NVS_STORE  = 3'd3,
      NVS_LOCK   = 3'd4
   } nvs_state_e;
endpackage

// File: rtl/nvs_host_gate.sv
module nvs_host_gate (
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic pin_n,
   input  logic allow,
   output logic rd_en,
   output logic wr_en
);
   logic rd_dec, wr_dec;
   always_comb begin
      rd_dec = !ce_n && !oe_n && we_n && pin_n;
      wr_dec = !ce_n && !we_n && pin_n;
      rd_en  = rd_dec && allow;
      wr_en  = wr_dec && allow;
   end
endmodule

// File: rtl/nvs_dirty_track.sv
module nvs_dirty_track (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_seen,
   input  logic xfer_done,
   output logic dirty
);
   always_ff @(posedge clk) begin
      if (!rst_n)         dirty <= 1'b0;
      else if (xfer_done) dirty <= 1'b0;
      else if (wr_seen)   dirty <= 1'b1;
   end
endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
   import nvs_pkg::*;
#(
   parameter int HOLD_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_n,
   input  logic       sw_req,
   input  logic       pf_req,
   input  logic       dirty_now,
   input  logic       done,
   output nvs_state_e state
);
   localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

   nvs_state_e       state_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;
   logic             cond_req;

   always_comb begin
      cond_req = (!pin_n || pf_req) && dirty_now;
      state_nx = state;
      cnt_nx   = cnt;
      case (state)
         NVS_RECALL: if (done) state_nx = NVS_IDLE;
         NVS_IDLE: begin
            if (sw_req || cond_req) begin
               state_nx = NVS_HOLD;
               cnt_nx   = '0;
            end
         end
         NVS_HOLD: begin
            if (cnt == CNT_LAST) state_nx = NVS_STORE;
            else                 cnt_nx   = cnt + 1'b1;
         end
         NVS_STORE: if (done) state_nx = pin_n ? NVS_IDLE : NVS_LOCK;
         NVS_LOCK:  if (pin_n) state_nx = NVS_IDLE;
         default:   state_nx = NVS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= NVS_RECALL;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
      end
   end
endmodule

// File: rtl/nvs_seq_top.sv
module nvs_seq_top
   import nvs_pkg::*;
#(
   parameter int HOLD_CYCLES   = 4,
   parameter bit AUTO_STORE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_ce_n,
   input  logic host_oe_n,
   input  logic host_we_n,
   input  logic hw_store_n,
   input  logic sw_store,
   input  logic pwr_fail,
   input  logic eng_done,
   output logic host_rd_en,
   output logic host_wr_en,
   output logic busy_n,
   output logic eng_store_req,
   output logic eng_recall_req
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
   endgenerate

   nvs_state_e state;
   logic       allow, dirty, pf_req, xfer_done;

   generate
      if (AUTO_STORE_EN) begin : g_auto_on
         assign pf_req = pwr_fail;
      end else begin : g_auto_off
         assign pf_req = pwr_fail & 1'b0;
      end
   endgenerate

   assign allow          = (state == NVS_IDLE) || (state == NVS_HOLD);
   assign eng_store_req  = (state == NVS_STORE);
   assign eng_recall_req = (state == NVS_RECALL);
   assign busy_n         = !((state == NVS_HOLD) || (state == NVS_STORE));
   assign xfer_done      = eng_done && (eng_store_req || eng_recall_req);

   nvs_host_gate u_gate (
      .ce_n (host_ce_n),
      .oe_n (host_oe_n),
      .we_n (host_we_n),
      .pin_n(hw_store_n),
      .allow(allow),
      .rd_en(host_rd_en),
      .wr_en(host_wr_en)
   );

   nvs_dirty_track u_dirty (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_seen  (host_wr_en),
      .xfer_done(xfer_done),
      .dirty    (dirty)
   );

   nvs_xfer_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (hw_store_n),
      .sw_req   (sw_store),
      .pf_req   (pf_req),
      .dirty_now(dirty || host_wr_en),
      .done     (eng_done),
      .state    (state)
   );
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic host_rd_en,
   input logic host_wr_en,
   input logic busy_n,
   input logic eng_store_req,
   input logic eng_recall_req,
   input logic eng_done
);
   AST_BUSY_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_store_req |-> !busy_n); // R8
   AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_store_req && eng_done) |=> busy_n); // R8
   AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_store_req && !eng_done) |=> eng_store_req); // R12
   AST_RECALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_recall_req && !eng_done) |=> eng_recall_req); // R1
   AST_NO_HOST_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_store_req || eng_recall_req) |-> !(host_rd_en || host_wr_en)); // R9
   AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_store_req && eng_recall_req)); // R12
endmodule

bind nvs_seq_top nvs_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_rd_en    (host_rd_en),
   .host_wr_en    (host_wr_en),
   .busy_n        (busy_n),
   .eng_store_req (eng_store_req),
   .eng_recall_req(eng_recall_req),
   .eng_done      (eng_done)
);

// File: tb/nvs_seq_top_bench.sv
module nvs_seq_top_bench;
   localparam int HOLD = 4;
   localparam int LAT  = 5;
   // {ce_n, oe_n, we_n, exp_rd, exp_wr} with hw_store_n high, idle state
   localparam logic [4:0] DEC_TAB [8] = '{
      5'b000_0_1, 5'b001_1_0, 5'b010_0_1, 5'b011_0_0,
      5'b100_0_0, 5'b101_0_0, 5'b110_0_0, 5'b111_0_0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic hw_n = 1'b1, sw = 1'b0, pf = 1'b0, done = 1'b0;
   logic rd_en, wr_en, busy_n, sreq, rreq;
   int   n_chk = 0, n_fail = 0, eng_cnt = 0, n_starts = 0;
   logic sreq_q = 1'b0;

   always #4 clk = ~clk;

   nvs_seq_top #(.HOLD_CYCLES(HOLD)) u_nvs_seq_top (
      .clk(clk), .rst_n(rst_n), .host_ce_n(ce_n), .host_oe_n(oe_n),
      .host_we_n(we_n), .hw_store_n(hw_n), .sw_store(sw), .pwr_fail(pf),
      .eng_done(done), .host_rd_en(rd_en), .host_wr_en(wr_en),
      .busy_n(busy_n), .eng_store_req(sreq), .eng_recall_req(rreq)
   );

   // engine model: done pulse LAT cycles after a request is seen
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_cnt <= 0; done <= 1'b0;
      end else if ((sreq || rreq) && !done) begin
         if (eng_cnt == LAT - 1) begin done <= 1'b1; eng_cnt <= 0; end
         else eng_cnt <= eng_cnt + 1;
      end else done <= 1'b0;
      sreq_q <= sreq;
      if (rst_n && sreq && !sreq_q) n_starts <= n_starts + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 300; i++) begin
         if (!sreq && !rreq && busy_n) break;
         step();
      end
   endtask

   task automatic strobes(input logic c, input logic o, input logic w);
      ce_n = c; oe_n = o; we_n = w; #1;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state and recall
      strobes(0, 0, 1);
      step(); step();
      chk("R1 recall req in reset", int'(rreq), 1);
      chk("R1 rd blocked in reset", int'(rd_en), 0);
      chk("R8 busy idle in reset", int'(busy_n), 1);
      rst_n = 1'b1;
      step();
      chk("R1 recall held", int'(rreq), 1);
      chk("R9 rd blocked in recall", int'(rd_en), 0);
      wait_idle();
      chk("R1 recall ended", int'(rreq), 0);
      chk("R2 rd after recall", int'(rd_en), 1);
      strobes(1, 1, 1);

      // R4 / R1: recall leaves flag clean, hardware pin ignored
      hw_n = 1'b0;
      for (int i = 0; i < HOLD + 4; i++) step();
      chk("R4 busy with clean flag", int'(busy_n), 1);
      chk("R4 no store with clean flag", n_starts, 0);
      hw_n = 1'b1; step();

      // R2 R3: decode table
      for (int i = 0; i < 8; i++) begin
         strobes(DEC_TAB[i][4], DEC_TAB[i][3], DEC_TAB[i][2]);
         chk("R2 read decode", int'(rd_en), int'(DEC_TAB[i][1]));
         chk("R3 write decode", int'(wr_en), int'(DEC_TAB[i][0]));
         step();
      end
      strobes(1, 1, 1);

      // R10 R11: hardware store with dirty flag, pin held past done
      hw_n = 1'b0; step();
      chk("R8 busy after hw accept", int'(busy_n), 0);
      for (int i = 0; i < 40 && !(sreq && done); i++) step();
      step();
      chk("R8 busy released", int'(busy_n), 1);
      chk("R11 one hw store", n_starts, 1);
      step();
      hw_n = 1'b1; strobes(0, 0, 1);
      chk("R10 access held in lock", int'(rd_en), 0);
      step();
      chk("R10 access after pin high", int'(rd_en), 1);
      strobes(1, 1, 1);
      hw_n = 1'b0;
      for (int i = 0; i < HOLD + 4; i++) step();
      chk("R11 clean after store", n_starts, 1);
      hw_n = 1'b1; step(); step();

      // R5: power fail clean, then with a write in the same cycle
      pf = 1'b1;
      for (int i = 0; i < 3; i++) step();
      chk("R5 pf ignored when clean", int'(busy_n), 1);
      strobes(0, 1, 0);
      chk("R3 write during pf", int'(wr_en), 1);
      step();
      pf = 1'b0; strobes(1, 1, 1);
      chk("R5 pf with same-cycle write", int'(busy_n), 0);
      wait_idle();
      chk("R5 pf store ran", n_starts, 2);

      // R6 R7: software store on a clean flag, hold window timing
      strobes(0, 0, 1);
      sw = 1'b1; step(); sw = 1'b0;
      chk("R6 sw store accepted", int'(busy_n), 0);
      chk("R7 rd open in hold", int'(rd_en), 1);
      for (int i = 0; i < HOLD - 1; i++) step();
      chk("R7 store not yet", int'(sreq), 0);
      step();
      chk("R7 store starts", int'(sreq), 1);
      chk("R9 rd blocked in store", int'(rd_en), 0);
      // R12: second sw request during store is dropped
      sw = 1'b1; step(); sw = 1'b0;
      wait_idle();
      for (int i = 0; i < HOLD + 3; i++) step();
      chk("R12 no queued store", n_starts, 3);
      chk("R12 busy released", int'(busy_n), 1);
      chk("R6 access back", int'(rd_en), 1);
      strobes(1, 1, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule